// File: doc/BRIEF.md
# Clock Crosspoint With Post Dividers

This block takes four clock sources and drives three clock outputs. Each output has its own route setting that picks one of the sources and can invert it, and a seven-bit post divider behind that. Outputs A and B each hold two divide values, and a shared frequency-select input picks between them. Output C holds one divide value and does not respond to frequency select. Routing two outputs from one source with opposite phase keeps their edges apart.

The block runs on a core clock. The four sources arrive as level signals generated in step with that clock, and each must be at least two core cycles long. A divider counts rising edges of its tapped source. Every output is a registered core-clock signal. A small write port loads the route and divide registers. Divide values and frequency select are taken up only at a period boundary. A route change mutes the output and then restarts its divider cleanly.

Top module: `clkxp_top`

## Requirements
- R1: Route code bits [1:0] select the source: 0 is the reference, and 1, 2 and 3 are the first, second and third PLL clock. Any code can be used on any output.
- R2: With a divide value N from 2 to 127, an output has a period of exactly N source periods.
- R3: With N of 2 or more, the output is high for floor(N/2) source periods and low for the rest of the period.
- R4: For output A and output B, frequency select 0 picks the first divide register and 1 picks the second. Output C has one divide register and its output is the same for either level of frequency select.
- R5: A divide value of 0 holds the output low.
- R6: A divide value of 1 passes the tapped source through with a delay of one core cycle. The source period and high time are kept.
- R7: Route bit 2 inverts the tapped source. Two outputs set to N=1 on one source, one of them inverted, are complementary.
- R8: A new divide value, from a register write or a change of frequency select, is loaded only at the divider's terminal count. No high or low pulse is shorter than the shorter of the old and new half periods.
- R9: When a route setting changes, the output goes low and stays low until two rising edges of the new tap have been seen, which is at least one full source period. The divider then restarts at the start of a period. Leaving reset behaves the same way.
- R10: Write port map (3-bit address, 7-bit data). Addresses 0, 1 and 2 are the route registers of outputs A, B and C (bits [2:0]). Address 3 is divide A/select0 and 4 is divide A/select1. Address 5 is divide B/select0 and 6 is divide B/select1. Address 7 is divide C.
- R11: While reset is held and after it is released, every output is low and all registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 4 | Source levels: bit 0 is the reference, bits 1 to 3 are the PLL clocks |
| fs_i | input | 1 | Frequency select for outputs A and B |
| cfg_we_i | input | 1 | Write strobe for the configuration port |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 7 | Write data |
| clk_o | output | 3 | Divided outputs: bit 0 is A, bit 1 is B, bit 2 is C |

## Verification
The assertions rely on the source levels being synchronous to the core clock, so that each tap rise is seen as a single-cycle event. Each high and low phase must last at least one core cycle. The bench meets this by changing every source on the falling core edge, with half periods of 1, 2, 3 and 5 core cycles. Configuration writes and frequency-select changes are driven on the falling edge as well, one at a time, so each takes effect at one known rising edge. The bench then measures periods, high times and the shortest pulses from whole edges only.

// File: rtl/clkxp_pkg.sv
package clkxp_pkg;
    localparam int SRC_N   = 4;
    localparam int OUT_N   = 3;
    localparam int FS_N    = 2;   // outputs that carry a second divide register
    localparam int DIV_W   = 7;
    localparam int ADDR_W  = 3;

    typedef enum logic [1:0] {
        M_WAIT1 = 2'd0,   // muted, waiting for first rise of new tap
        M_WAIT2 = 2'd1,   // muted, waiting for second rise
        M_RUN   = 2'd2    // dividing
    } chan_mode_e;
endpackage

// File: rtl/clkxp_cfg.sv
module clkxp_cfg
    import clkxp_pkg::*;
#(
    parameter int N_OUT  = OUT_N,
    parameter int N_FS   = FS_N,
    parameter int DW     = DIV_W,
    parameter int RW     = 3,
    parameter int AW     = ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [AW-1:0]                 addr_i,
    input  logic [DW-1:0]                 wdata_i,
    output logic [N_OUT-1:0][RW-1:0]      route_o,
    output logic [N_OUT-1:0][DW-1:0]      div_lo_o,
    output logic [N_OUT-1:0][DW-1:0]      div_hi_o
);
    localparam int DIV_N = N_OUT + N_FS;

    typedef struct packed {
        logic [N_OUT-1:0][RW-1:0] route;
        logic [DIV_N-1:0][DW-1:0] div;
    } cfg_st_t;

    cfg_st_t cfg_q, cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        for (int i = 0; i < N_OUT; i++) begin
            if (we_i && addr_i == AW'(i))
                cfg_d.route[i] = wdata_i[RW-1:0];
        end
        for (int j = 0; j < DIV_N; j++) begin
            if (we_i && addr_i == AW'(N_OUT + j))
                cfg_d.div[j] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    for (genvar c = 0; c < N_OUT; c++) begin : g_map
        localparam int LO = (c < N_FS) ? 2 * c : N_FS + c;
        localparam int HI = (c < N_FS) ? 2 * c + 1 : LO;
        assign route_o[c]  = cfg_q.route[c];
        assign div_lo_o[c] = cfg_q.div[LO];
        assign div_hi_o[c] = cfg_q.div[HI];
    end
endmodule

// File: rtl/clkxp_chan.sv
module clkxp_chan
    import clkxp_pkg::*;
#(
    parameter int N_SRC = SRC_N,
    parameter int DW    = DIV_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_SRC-1:0]           src_i,
    input  logic [$clog2(N_SRC):0]     route_i,
    input  logic [DW-1:0]              div_i,
    output logic                       clk_o
);
    localparam int SEL_W = $clog2(N_SRC);
    localparam int RW    = SEL_W + 1;

    typedef struct packed {
        chan_mode_e     mode;
        logic [RW-1:0]  route;
        logic           tap;
        logic           out;
        logic [DW-1:0]  cnt;
        logic [DW-1:0]  act;
    } chan_st_t;

    chan_st_t st_q, st_d;
    logic tap_w, rise_w, term_w;

    always_comb begin
        tap_w  = src_i[route_i[SEL_W-1:0]] ^ route_i[RW-1];
        rise_w = tap_w & ~st_q.tap;
        term_w = (st_q.act <= DW'(1)) || (st_q.cnt == st_q.act - DW'(1));

        st_d     = st_q;
        st_d.tap = tap_w;
        if (route_i != st_q.route) begin
            st_d.route = route_i;
            st_d.mode  = M_WAIT1;
            st_d.cnt   = '0;
            st_d.out   = 1'b0;
        end else begin
            unique case (st_q.mode)
                M_WAIT1: if (rise_w) st_d.mode = M_WAIT2;
                M_WAIT2: if (rise_w) begin
                    st_d.mode = M_RUN;
                    st_d.act  = div_i;
                    st_d.cnt  = '0;
                    st_d.out  = (div_i != '0);
                end
                default: begin
                    if (rise_w) begin
                        if (term_w) begin
                            st_d.cnt = '0;
                            st_d.act = div_i;
                            st_d.out = (div_i != '0);
                        end else begin
                            st_d.cnt = st_q.cnt + DW'(1);
                            st_d.out = (st_q.cnt + DW'(1)) < (st_q.act >> 1);
                        end
                    end else if (st_q.act == DW'(1)) begin
                        st_d.out = tap_w;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{mode: M_WAIT1, default: '0};
        else        st_q <= st_d;
    end

    assign clk_o = st_q.out;

    p_hold_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != M_RUN) |-> !st_q.out);

    p_act_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.act) |-> $past(rise_w));

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_RUN && st_q.act >= DW'(2)) |-> (st_q.cnt < st_q.act));

    p_zero_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_RUN && st_q.act == '0 &&
         $past(st_q.mode == M_RUN && st_q.act == '0)) |-> !st_q.out);
endmodule

// File: rtl/clkxp_top.sv
module clkxp_top
    import clkxp_pkg::*;
#(
    parameter int N_SRC = SRC_N,
    parameter int N_OUT = OUT_N,
    parameter int N_FS  = FS_N,
    parameter int DW    = DIV_W,
    parameter int AW    = ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   src_i,
    input  logic               fs_i,
    input  logic               cfg_we_i,
    input  logic [AW-1:0]      cfg_addr_i,
    input  logic [DW-1:0]      cfg_wdata_i,
    output logic [N_OUT-1:0]   clk_o
);
    localparam int RW = $clog2(N_SRC) + 1;

    logic [N_OUT-1:0][RW-1:0] route_w;
    logic [N_OUT-1:0][DW-1:0] div_lo_w, div_hi_w, div_sel_w;

    clkxp_cfg #(.N_OUT(N_OUT), .N_FS(N_FS), .DW(DW), .RW(RW), .AW(AW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (cfg_we_i),
        .addr_i   (cfg_addr_i),
        .wdata_i  (cfg_wdata_i),
        .route_o  (route_w),
        .div_lo_o (div_lo_w),
        .div_hi_o (div_hi_w)
    );

    for (genvar c = 0; c < N_OUT; c++) begin : g_out
        if (c < N_FS) begin : g_fs
            assign div_sel_w[c] = fs_i ? div_hi_w[c] : div_lo_w[c];
        end else begin : g_fixed
            assign div_sel_w[c] = div_lo_w[c];
        end

        clkxp_chan #(.N_SRC(N_SRC), .DW(DW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (src_i),
            .route_i (route_w[c]),
            .div_i   (div_sel_w[c]),
            .clk_o   (clk_o[c])
        );
    end

    p_reset_low_r11: assert property (@(posedge clk)
        $past(!rst_n) |-> (clk_o == '0));
endmodule

// File: tb/tb_clkxp_top.sv
module tb_clkxp_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src = '0;
    logic       fs = 1'b0;
    logic       we = 1'b0;
    logic [2:0] addr = '0;
    logic [6:0] wdata = '0;
    logic [2:0] clk_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    clkxp_top dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .fs_i(fs),
        .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .clk_o(clk_out)
    );

    always #5 clk = ~clk;

    // source half periods 1,2,3,5 core cycles -> periods 2,4,6,10
    int hc [4];
    localparam int HALF [4] = '{1, 2, 3, 5};
    always @(negedge clk) begin
        for (int k = 0; k < 4; k++) begin
            if (hc[k] >= HALF[k] - 1) begin hc[k] <= 0; src[k] <= ~src[k]; end
            else hc[k] <= hc[k] + 1;
        end
    end

    // table: channel, source code, invert, divide, expected period, expected high
    localparam int NV = 8;
    localparam int V_CH  [NV] = '{2, 0, 1, 2, 0, 1, 2, 0};
    localparam int V_SEL [NV] = '{0, 1, 2, 3, 1, 3, 2, 0};
    localparam int V_INV [NV] = '{0, 0, 0, 0, 0, 1, 0, 1};
    localparam int V_DIV [NV] = '{4, 3, 5, 2, 1, 7, 127, 6};
    localparam int V_PER [NV] = '{8, 12, 30, 20, 4, 70, 762, 12};
    localparam int V_HI  [NV] = '{4, 4, 12, 10, 2, 30, 378, 6};
    localparam int DIV_ADDR [3] = '{3, 5, 7};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        we = 1'b1; addr = 3'(a); wdata = 7'(d);
        @(negedge clk);
        we = 1'b0;
    endtask

    // write route twice so the channel always re-enters the hold state
    task automatic route(input int ch, input int sel, input int inv);
        wr(ch, ((inv ^ 1) << 2) | sel);
        wr(ch, (inv << 2) | sel);
    endtask

    task automatic measure_once(input int ch, output int per, output int hi);
        int n = 0;
        logic prev = clk_out[ch];
        bit highph = 1;
        per = -1; hi = -1;
        while (n < 4000) begin
            @(negedge clk); n++;
            if (!prev && clk_out[ch]) break;
            prev = clk_out[ch];
        end
        if (n >= 4000) return;
        per = 0; hi = 1; prev = 1'b1;
        while (per < 4000) begin
            @(negedge clk); per++;
            if (!prev && clk_out[ch]) break;
            if (highph && clk_out[ch]) hi++;
            else highph = 0;
            prev = clk_out[ch];
        end
    endtask

    task automatic measure(input int ch, output int per, output int hi);
        int p, h;
        measure_once(ch, p, h);
        measure_once(ch, per, hi);
    endtask

    task automatic pulses(input int ch, input int cyc, output int mhi, output int mlo);
        logic prev = clk_out[ch];
        int run = 0;
        bit seen = 0;
        mhi = 9999; mlo = 9999;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (clk_out[ch] != prev) begin
                if (seen) begin
                    if (prev) mhi = (run < mhi) ? run : mhi;
                    else      mlo = (run < mlo) ? run : mlo;
                end
                seen = 1; run = 1;
            end else run++;
            prev = clk_out[ch];
        end
    endtask

    initial begin
        int per, hi, mhi, mlo, cnt;
        bit ok;
        for (int k = 0; k < 4; k++) hc[k] = 0;
        // R11: outputs low during and after reset
        repeat (4) @(negedge clk);
        chk(clk_out == 3'b000, "R11 during reset", int'(clk_out), 0);
        rst_n = 1'b1;
        ok = 1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (clk_out != 3'b000) ok = 0;
        end
        chk(ok, "R11 after reset", int'(clk_out), 0);

        // table walk: R1 R2 R3 R6 R7 R10
        for (int v = 0; v < NV; v++) begin
            wr(DIV_ADDR[V_CH[v]], V_DIV[v]);
            route(V_CH[v], V_SEL[v], V_INV[v]);
            measure(V_CH[v], per, hi);
            chk(per == V_PER[v], $sformatf("R1 R2 R10 period vec%0d", v), per, V_PER[v]);
            chk(hi == V_HI[v], $sformatf("R3 R6 high vec%0d", v), hi, V_HI[v]);
        end

        // R7: complementary outputs from one source
        wr(3, 1); wr(5, 1);
        route(0, 1, 0); route(1, 1, 1);
        repeat (40) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (clk_out[0] == clk_out[1]) cnt++;
        end
        chk(cnt == 0, "R7 inverted tap mismatches", cnt, 0);

        // R4 and R8: frequency select on output A, source period 10
        fs = 1'b0;
        wr(3, 2); wr(4, 4);
        route(0, 3, 0);
        measure(0, per, hi);
        chk(per == 20 && hi == 10, "R4 A select0 period", per, 20);
        @(negedge clk); fs = 1'b1;
        pulses(0, 200, mhi, mlo);
        chk(mhi >= 10 && mlo >= 10, "R8 fs change min pulse", (mhi < mlo) ? mhi : mlo, 10);
        measure(0, per, hi);
        chk(per == 40 && hi == 20, "R4 A select1 period", per, 40);
        wr(4, 2);
        pulses(0, 200, mhi, mlo);
        chk(mhi >= 10 && mlo >= 10, "R8 divide write min pulse", (mhi < mlo) ? mhi : mlo, 10);

        // R4: output B second register
        wr(5, 2); wr(6, 6);
        route(1, 0, 0);
        measure(1, per, hi);
        chk(per == 12 && hi == 6, "R4 B select1 period", per, 12);

        // R4: output C ignores select
        wr(7, 3);
        route(2, 1, 0);
        measure(2, per, hi);
        chk(per == 12, "R4 C with fs=1", per, 12);
        @(negedge clk); fs = 1'b0;
        measure(2, per, hi);
        chk(per == 12 && hi == 4, "R4 C with fs=0", per, 12);

        // R9: route change mutes output, then restarts
        wr(3, 2);
        route(0, 0, 0);
        repeat (30) @(negedge clk);
        wr(0, 3);
        @(negedge clk);
        cnt = 0;
        while (!clk_out[0] && cnt < 100) begin @(negedge clk); cnt++; end
        chk(cnt >= 10 && cnt <= 22, "R9 hold length", cnt, 10);
        measure(0, per, hi);
        chk(per == 20 && hi == 10, "R9 restart period", per, 20);

        // R5: divide 0 holds low
        wr(7, 0);
        route(2, 0, 0);
        repeat (20) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (clk_out[2]) cnt++;
        end
        chk(cnt == 0, "R5 zero divide high samples", cnt, 0);

        // R11: reset in mid run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(clk_out == 3'b000, "R11 mid-run reset", int'(clk_out), 0);
        rst_n = 1'b1;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R11 watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule